// File: doc/BRIEF.md
# Clock and Reset Control Register Bank

This block is the clock and reset control point of a small subsystem. Software reaches it over a simple 32-bit register bus: a write strobe with byte address and data, and a read data output that follows the address with no wait states. One configuration register holds three 2-bit power-of-two divider selects. From the one reference clock, the block makes a clock-enable strobe for each of three domains: CPU, main AXI and peripheral AHB. Each strobe lasts one reference cycle.

Two further registers share one 30-bit peripheral index. Bit k of the gate register runs the clock of peripheral k. Bit k of the hold register keeps peripheral k in reset. Software brings a peripheral up by setting its gate bit and then clearing its hold bit, and shuts it down in the reverse order. A fourth register starts a subsystem reset pulse, but only when a fixed key value is written to it.

Top module: `clkrst_ctrl`

## Requirements
- R1: After reset, all divider fields are 0, every gate bit is 0, every hold bit (29..0) is 1, the key register reads 0 and `sys_rst` is low.
- R2: The configuration register sits at byte offset 0x08. Bits [1:0] select the CPU divider, bits [3:2] the AXI divider and bits [5:4] the AHB divider. It reads back bits [5:0] as written and all higher bits as 0.
- R3: For a settled field value n, the strobe of that domain (`div_stb` bit 0 for CPU, bit 1 for AXI, bit 2 for AHB) is high for one cycle in every 2^n cycles.
- R4: A new divider value takes effect only at the next terminal count of that domain's counter, so the period that is running when the field changes completes at its full length.
- R5: The gate register sits at 0x84. Bit k drives `periph_gate[k]` for k = 0..29. Bit 17 is reserved: it reads 0 and its output stays 0. Bits 31..30 read 0.
- R6: The hold register sits at 0x88. Bit k drives `periph_hold[k]` for k = 0..29, bit 17 included. Bits 31..30 read 0.
- R7: A write to the gate register leaves the hold outputs unchanged, and the reverse also holds, so the bring-up and shutdown orders are kept write by write.
- R8: Writing exactly 0x0000DEAD to the key register at 0x18 drives `sys_rst` high from the cycle after the write for exactly 16 cycles.
- R9: Writing any other value to 0x18 leaves `sys_rst` unchanged. A key write while a pulse is running neither extends nor restarts it.
- R10: The key register reads back the last value written to it, whether or not that value was the key.
- R11: Writes to unmapped offsets change no register and no output. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| div_stb | output | 3 | Clock-enable strobes: bit 0 CPU, bit 1 AXI, bit 2 AHB |
| periph_gate | output | 30 | Per-peripheral clock run enables |
| periph_hold | output | 30 | Per-peripheral reset holds, high means held |
| sys_rst | output | 1 | Subsystem reset pulse |

## Verification
The hardest case to reach from the ports is a divider change that lands in the middle of a long period. The old period must finish at full length before the new ratio applies. The bench reaches this case in two steps. It first waits to see an AHB strobe while the divide-by-8 setting is in force. It then writes divide-by-1 a fixed number of cycles later and counts cycles to the next strobe. The second hard case is a key write that arrives during a running reset pulse. The bench issues this write from inside the loop that measures the pulse, so the total high time shows whether the pulse was extended or restarted.

// File: rtl/clkrst_pkg.sv
// Shared constants for the clock and reset control bank: register offsets,
// the reset key, the peripheral index width and the reserved gate bit.
package clkrst_pkg;
    localparam int unsigned DATA_W        = 32;
    localparam int unsigned PERIPH_N      = 30;
    localparam int unsigned RSVD_GATE_BIT = 17;
    localparam int unsigned OFF_CFG       = 'h008;
    localparam int unsigned OFF_KEY       = 'h018;
    localparam int unsigned OFF_GATE      = 'h084;
    localparam int unsigned OFF_HOLD      = 'h088;
    localparam logic [DATA_W-1:0] SYS_KEY = 32'h0000_DEAD;
endpackage

// File: rtl/clkrst_div.sv
// One divided clock-enable domain.
// Emits a one-cycle strobe every 2^n cycles, where n is the select value
// captured at the last terminal count. Assumes sel_in may change at any time.
module clkrst_div #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_in,
    output logic             stb
);
    localparam int unsigned CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [SEL_W-1:0] cur_q;
    logic [CNT_W:0]   ratio;
    logic [CNT_W-1:0] lim;

    // Terminal count value for the select currently in force.
    always_comb begin
        ratio = {{CNT_W{1'b0}}, 1'b1} << cur_q;
        lim   = ratio[CNT_W-1:0] - 1'b1;
        stb   = (cnt_q == lim);
    end

    // Count up; on terminal count, wrap to zero and adopt the new select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cur_q <= '0;
        end else if (stb) begin
            cnt_q <= '0;
            cur_q <= sel_in;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/clkrst_regs.sv
// Register file of the control bank: configuration, gate, hold and key registers.
// Provides the combinational read mux and a key-hit flag.
// Assumes single-cycle writes and no wait states.
module clkrst_regs
    import clkrst_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned CFG_W  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [CFG_W-1:0]    cfg_q,
    output logic [PERIPH_N-1:0] gate_q,
    output logic [PERIPH_N-1:0] hold_q,
    output logic                key_hit
);
    localparam logic [PERIPH_N-1:0] GATE_MASK = ~({{(PERIPH_N-1){1'b0}}, 1'b1} << RSVD_GATE_BIT);

    logic [DATA_W-1:0] key_q;
    logic sel_cfg, sel_key, sel_gate, sel_hold;

    // Address decode of the four mapped offsets.
    always_comb begin
        sel_cfg  = (bus_addr == ADDR_W'(OFF_CFG));
        sel_key  = (bus_addr == ADDR_W'(OFF_KEY));
        sel_gate = (bus_addr == ADDR_W'(OFF_GATE));
        sel_hold = (bus_addr == ADDR_W'(OFF_HOLD));
        key_hit  = bus_wr && sel_key && (bus_wdata == SYS_KEY);
    end

    // Register writes; reserved bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            gate_q <= '0;
            hold_q <= '1;
            key_q  <= '0;
        end else if (bus_wr) begin
            if (sel_cfg)  cfg_q  <= bus_wdata[CFG_W-1:0];
            if (sel_gate) gate_q <= bus_wdata[PERIPH_N-1:0] & GATE_MASK;
            if (sel_hold) hold_q <= bus_wdata[PERIPH_N-1:0];
            if (sel_key)  key_q  <= bus_wdata;
        end
    end

    // Read mux; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (sel_cfg)  bus_rdata = {{(DATA_W-CFG_W){1'b0}}, cfg_q};
        if (sel_gate) bus_rdata = {{(DATA_W-PERIPH_N){1'b0}}, gate_q};
        if (sel_hold) bus_rdata = {{(DATA_W-PERIPH_N){1'b0}}, hold_q};
        if (sel_key)  bus_rdata = key_q;
    end
endmodule

// File: rtl/clkrst_pulse.sv
// Subsystem reset pulse generator.
// A key hit while idle starts a high pulse of PULSE_LEN cycles.
// Key hits during a pulse are ignored.
module clkrst_pulse #(
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_hit,
    output logic sys_rst
);
    localparam int unsigned CW = $clog2(PULSE_LEN + 1);

    logic [CW-1:0] cnt_q;

    // Load on an idle key hit, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (key_hit && cnt_q == '0)  cnt_q <= CW'(PULSE_LEN);
        else if (cnt_q != '0)             cnt_q <= cnt_q - 1'b1;
    end

    // Pulse is high while the counter is running.
    always_comb sys_rst = (cnt_q != '0);
endmodule

// File: rtl/clkrst_ctrl.sv
// Top of the clock and reset control bank.
// Ties the register file to one divider per domain and to the key pulse generator.
// Domain d takes its select from cfg bits [d*SEL_W +: SEL_W].
module clkrst_ctrl
    import clkrst_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned SEL_W     = 2,
    parameter int unsigned N_DOM     = 3,
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [N_DOM-1:0]    div_stb,
    output logic [PERIPH_N-1:0] periph_gate,
    output logic [PERIPH_N-1:0] periph_hold,
    output logic                sys_rst
);
    localparam int unsigned CFG_W = N_DOM * SEL_W;

    logic [CFG_W-1:0] cfg_q;
    logic             key_hit;

    clkrst_regs #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_q     (cfg_q),
        .gate_q    (periph_gate),
        .hold_q    (periph_hold),
        .key_hit   (key_hit)
    );

    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        clkrst_div #(.SEL_W(SEL_W)) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel_in (cfg_q[d*SEL_W +: SEL_W]),
            .stb    (div_stb[d])
        );
    end

    clkrst_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_hit (key_hit),
        .sys_rst (sys_rst)
    );
endmodule

// File: rtl/clkrst_ctrl_chk.sv
// Property checker for clkrst_ctrl, attached by bind below.
// Observes the ports and the configuration register only.
module clkrst_ctrl_chk
    import clkrst_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned SEL_W     = 2,
    parameter int unsigned N_DOM     = 3,
    parameter int unsigned PULSE_LEN = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_wr,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [DATA_W-1:0]        bus_wdata,
    input logic [N_DOM-1:0]         div_stb,
    input logic [PERIPH_N-1:0]      periph_gate,
    input logic [PERIPH_N-1:0]      periph_hold,
    input logic                     sys_rst,
    input logic [N_DOM*SEL_W-1:0]   cfg
);
    localparam int unsigned GW = (1 << SEL_W) + 1;
    localparam int unsigned RW = $clog2(PULSE_LEN + 2);

    logic [RW-1:0] run_q;

    // Length of the current high run of sys_rst.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= '0;
        else if (sys_rst) run_q <= run_q + 1'b1;
        else              run_q <= '0;
    end

    // R8
    sysrst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> run_q == RW'(PULSE_LEN));

    // R8
    sysrst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_KEY) && bus_wdata == SYS_KEY && !sys_rst) |=> sys_rst);

    // R9
    sysrst_badkey_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_KEY) && bus_wdata != SYS_KEY && !sys_rst) |=> !sys_rst);

    // R5
    gate_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_gate[RSVD_GATE_BIT]);

    // R6
    hold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_HOLD)) |=> periph_hold == $past(bus_wdata[PERIPH_N-1:0]));

    for (genvar d = 0; d < N_DOM; d++) begin : g_gap
        logic [GW-1:0] gap_q;
        logic [GW-1:0] exp_q;

        // Cycles since the last strobe, and the period due after it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gap_q <= GW'(1);
                exp_q <= GW'(1);
            end else if (div_stb[d]) begin
                gap_q <= GW'(1);
                exp_q <= GW'(1) << cfg[d*SEL_W +: SEL_W];
            end else begin
                gap_q <= gap_q + 1'b1;
            end
        end

        // R3 R4
        stb_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
            div_stb[d] |-> gap_q == exp_q);
    end
endmodule

bind clkrst_ctrl clkrst_ctrl_chk #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .N_DOM(N_DOM), .PULSE_LEN(PULSE_LEN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .div_stb     (div_stb),
    .periph_gate (periph_gate),
    .periph_hold (periph_hold),
    .sys_rst     (sys_rst),
    .cfg         (cfg_q)
);

// File: tb/clkrst_ctrl_tb.sv
module clkrst_ctrl_tb;
    localparam int unsigned PN = 30;
    localparam logic [31:0] PMASK = 32'h3FFF_FFFF;
    localparam logic [31:0] GMASK = 32'h3FFD_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  div_stb;
    logic [PN-1:0] periph_gate;
    logic [PN-1:0] periph_hold;
    logic        sys_rst;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    clkrst_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .div_stb(div_stb),
        .periph_gate(periph_gate), .periph_hold(periph_hold), .sys_rst(sys_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [31:0] gate_e;
        logic [31:0] hold_e;
        int cnt;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(12'h008, v); chk("R1 cfg", v, 32'h0);
        rd(12'h084, v); chk("R1 gate", v, 32'h0);
        rd(12'h088, v); chk("R1 hold", v, PMASK);
        rd(12'h018, v); chk("R1 key", v, 32'h0);
        chk("R1 sys_rst", {31'd0, sys_rst}, 32'd0);
        chk("R1 gate out", {2'b0, periph_gate}, 32'h0);
        chk("R1 hold out", {2'b0, periph_hold}, PMASK);
        chk("R1 stb div1", {29'd0, div_stb}, 32'd7);

        // R2 R3: exhaustive divider sweep
        for (int c = 0; c < 64; c++) begin
            wr(12'h008, 32'hFFFF_FFC0 | c);
            rd(12'h008, v); chk("R2 cfg readback", v, c);
            repeat (10) @(negedge clk);
            for (int d = 0; d < 3; d++) begin
                cnt = 0;
                for (int k = 0; k < 64; k++) begin
                    if (k > 0) @(negedge clk);
                    if (div_stb[d]) cnt++;
                end
                chk($sformatf("R3 dom%0d cfg%0d", d, c), cnt, 64 >> ((c >> (2*d)) & 3));
            end
        end

        // R4: shorten the ratio mid-period; the running period completes
        wr(12'h008, 32'h30);
        repeat (10) @(negedge clk);
        while (!div_stb[2]) @(negedge clk);
        cyc = 0;
        @(negedge clk); cyc++;
        bus_wr = 1'b1; bus_addr = 12'h008; bus_wdata = 32'h0;
        @(negedge clk); cyc++;
        bus_wr = 1'b0;
        while (!div_stb[2] && cyc < 20) begin
            @(negedge clk); cyc++;
        end
        chk("R4 old period kept", cyc, 8);
        @(negedge clk); chk("R4 new ratio", {31'd0, div_stb[2]}, 32'd1);
        @(negedge clk); chk("R4 new ratio next", {31'd0, div_stb[2]}, 32'd1);

        // R5 R7: walking one through the gate register
        hold_e = PMASK;
        wr(12'h088, hold_e);
        for (int b = 0; b < 32; b++) begin
            gate_e = (b < 30 && b != 17) ? (32'd1 << b) : 32'd0;
            wr(12'h084, 32'd1 << b);
            rd(12'h084, v); chk($sformatf("R5 gate rd b%0d", b), v, gate_e);
            chk($sformatf("R5 gate out b%0d", b), {2'b0, periph_gate}, gate_e);
            chk($sformatf("R7 hold kept b%0d", b), {2'b0, periph_hold}, hold_e);
        end
        wr(12'h084, 32'hFFFF_FFFF);
        rd(12'h084, v); chk("R5 gate all ones", v, GMASK);
        gate_e = GMASK;

        // R6 R7: walking one through the hold register
        for (int b = 0; b < 32; b++) begin
            hold_e = (b < 30) ? (32'd1 << b) : 32'd0;
            wr(12'h088, 32'd1 << b);
            rd(12'h088, v); chk($sformatf("R6 hold rd b%0d", b), v, hold_e);
            chk($sformatf("R6 hold out b%0d", b), {2'b0, periph_hold}, hold_e);
            chk($sformatf("R7 gate kept b%0d", b), {2'b0, periph_gate}, gate_e);
        end

        // R7: bring-up then shutdown of peripheral 5
        wr(12'h084, 32'h0); wr(12'h088, PMASK);
        wr(12'h084, 32'h20);
        chk("R7 up gate", {2'b0, periph_gate}, 32'h20);
        chk("R7 up still held", {2'b0, periph_hold}, PMASK);
        wr(12'h088, PMASK & ~32'h20);
        chk("R7 up released", {2'b0, periph_hold}, PMASK & ~32'h20);
        chk("R7 up gate kept", {2'b0, periph_gate}, 32'h20);
        wr(12'h088, PMASK);
        chk("R7 down held", {2'b0, periph_hold}, PMASK);
        chk("R7 down gate kept", {2'b0, periph_gate}, 32'h20);
        wr(12'h084, 32'h0);
        chk("R7 down gated", {2'b0, periph_gate}, 32'h0);

        // R9 R10: wrong key values
        foreach (gate_e[i]) begin end
        for (int i = 0; i < 4; i++) begin
            v = (i == 0) ? 32'h0000_DEAE : (i == 1) ? 32'h0001_DEAD :
                (i == 2) ? 32'h0 : 32'hFFFF_FFFF;
            wr(12'h018, v);
            cnt = 0;
            for (int k = 0; k < 20; k++) begin
                if (sys_rst) cnt++;
                @(negedge clk);
            end
            chk($sformatf("R9 no pulse %h", v), cnt, 0);
            rd(12'h018, hold_e); chk("R10 key readback", hold_e, v);
        end

        // R8 R9: key pulse, second key during the pulse ignored
        wr(12'h018, 32'h0000_DEAD);
        chk("R8 pulse starts", {31'd0, sys_rst}, 32'd1);
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            if (sys_rst) cnt++;
            if (k == 4) begin bus_wr = 1'b1; bus_addr = 12'h018; bus_wdata = 32'h0000_DEAD; end
            if (k == 5) bus_wr = 1'b0;
            @(negedge clk);
        end
        chk("R8 R9 pulse length", cnt, 16);
        rd(12'h018, v); chk("R10 key value", v, 32'h0000_DEAD);

        // R11: unmapped writes and reads
        wr(12'h008, 32'h15); wr(12'h084, 32'h3); wr(12'h088, 32'h5);
        for (int i = 0; i < 6; i++) begin
            logic [11:0] a;
            a = (i == 0) ? 12'h000 : (i == 1) ? 12'h004 : (i == 2) ? 12'h00C :
                (i == 3) ? 12'h080 : (i == 4) ? 12'h08C : 12'h01C;
            wr(a, (i == 5) ? 32'h0000_DEAD : 32'hFFFF_FFFF);
            rd(a, v); chk($sformatf("R11 unmapped read %h", a), v, 32'h0);
        end
        chk("R11 no pulse", {31'd0, sys_rst}, 32'd0);
        rd(12'h008, v); chk("R11 cfg kept", v, 32'h15);
        rd(12'h084, v); chk("R11 gate kept", v, 32'h3);
        rd(12'h088, v); chk("R11 hold kept", v, 32'h5);
        rd(12'h018, v); chk("R11 key kept", v, 32'h0000_DEAD);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule